// File: doc/BRIEF.md
# Register-Triggered Memory Fill Engine

This block paints a range of byte-addressed memory with a repeating constant pattern. Software loads a first address, a stop address, a pattern value and a width selection into four register words. It then starts the work by writing the control word with its start bit set. The engine walks the range one 32-bit memory word at a time. It issues writes with per-byte enables on a valid/ready memory port, so patterns of 16 and 24 bits that do not line up with word boundaries are still laid down byte-exact.

The pattern is 16, 24 or 32 bits wide. The 24-bit pattern repeats every three bytes, so it drifts across the byte lanes of successive words. When the range has been covered, the engine drops its start bit, raises its finished bit and, provided the first address is not zero, pulses one interrupt line. A design that needs two fill channels places two copies with different `IRQ_LINE` values; each copy drives only its own bit of `irq_o`.

The memory port follows valid/ready rules. `mem_valid` rises only while a fill runs. Once it is raised, the address, data and byte enables stay frozen until the cycle in which `mem_ready` is seen high, and that cycle is the transfer. `mem_ready` may stay low for any number of cycles; the engine simply waits.

Top module: `mem_fill_engine`

## Requirements
- R1: A register write with `reg_sel`=0 stores the first address, 1 the stop address, 2 the pattern and 3 the control word (bit 0 start, bit 1 finished, bit 8 selects 24-bit, bit 9 selects 32-bit). A fill begins only on a control write with bit 0 set; a control write with bit 0 clear starts nothing.
- R2: If the stop address is not above the first address when the start bit is written, no memory write occurs, busy stays low, the start bit reads back as 1, the finished bit keeps the value just written, and no interrupt is raised.
- R3: In 16-bit mode (bits 8 and 9 clear), 2-byte steps begin at the first address and continue while the step address is below the stop address; each step puts pattern[7:0] at its first byte and pattern[15:8] at its second byte, so the last step may reach one byte past stop-1.
- R4: In 24-bit mode, 3-byte steps put pattern[7:0], pattern[15:8] and pattern[23:16] at offsets 0, 1 and 2, continuing while the step address is below the stop address.
- R5: In 32-bit mode, exactly floor((stop-first)/4) 4-byte steps are written, with pattern byte i at step offset i; if fewer than 4 bytes are in range, nothing is written but the fill still completes.
- R6: When bits 8 and 9 are both set, the fill behaves as 24-bit mode.
- R7: Each transfer carries a word-aligned `mem_addr`, a nonzero `mem_be` and, in each enabled lane, the byte the pattern places at that address; `mem_valid` and the request fields stay unchanged while `mem_ready` is low, and no byte outside the pattern's steps is written.
- R8: In the cycle busy falls, the start bit reads 0 and the finished bit reads 1, also when the first address is zero.
- R9: On completion, `irq_o[IRQ_LINE]` is high for exactly one cycle, the cycle in which busy is first seen low, but only when the first address is nonzero; every other `irq_o` bit stays 0.
- R10: Busy is high from the cycle after an accepted start write until completion, and `mem_valid` is low whenever busy is low; all register writes made while busy are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word: 0 first, 1 stop, 2 pattern, 3 control |
| reg_wdata | input | 32 | Register write data |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, byte lane i at bits 8i+7:8i |
| mem_be | output | 4 | Byte enables per lane |
| busy_o | output | 1 | Fill in progress |
| trig_o | output | 1 | Start bit of the control word |
| done_o | output | 1 | Finished bit of the control word |
| irq_o | output | N_IRQ | Completion pulses, only bit IRQ_LINE is used |

## Verification
Busy is due one edge after the start write: the bench drives writes at the falling edge and reads `busy_o` at the next falling edge. The first request is on the port in that same cycle. Every accepted transfer is compared, lane by lane, against a byte map the bench builds behaviourally at the rising edge where valid and ready are both high. The finished bit, the cleared start bit and the interrupt pulse all appear in the first cycle with busy low. The bench therefore counts interrupt pulses at every edge and reads the status bits at the falling edge where busy is first seen low. A rejected or inert write is judged a few cycles later, by looking at the memory image, `busy_o`, `trig_o` and the interrupt count.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  typedef enum logic [1:0] {
    FILL16 = 2'd0,
    FILL24 = 2'd1,
    FILL32 = 2'd2
  } fill_mode_e;

  localparam int SEL_START = 0;
  localparam int SEL_STOP  = 1;
  localparam int SEL_PAT   = 2;
  localparam int SEL_CTRL  = 3;

  localparam int CTL_GO    = 0;
  localparam int CTL_FIN   = 1;
  localparam int CTL_W24   = 8;
  localparam int CTL_W32   = 9;

  localparam int LANES     = 4;
endpackage

// File: rtl/mfe_regs.sv
module mfe_regs
  import mfe_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              complete,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] stop_q,
  output logic [31:0]       pat_q,
  output fill_mode_e        mode,
  output logic              go_q,
  output logic              fin_q,
  output logic              launch
);
  logic w24_q, w32_q;
  logic wr_ok;

  assign wr_ok  = we && !busy;
  assign launch = wr_ok && (sel == 2'(SEL_CTRL)) && wdata[CTL_GO] && (stop_q > first_q);

  always_comb begin
    if (w24_q)      mode = FILL24;
    else if (w32_q) mode = FILL32;
    else            mode = FILL16;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= '0;
      stop_q  <= '0;
      pat_q   <= '0;
      w24_q   <= 1'b0;
      w32_q   <= 1'b0;
      go_q    <= 1'b0;
      fin_q   <= 1'b0;
    end else if (wr_ok) begin
      case (sel)
        2'(SEL_START): first_q <= wdata[ADDR_W-1:0];
        2'(SEL_STOP):  stop_q  <= wdata[ADDR_W-1:0];
        2'(SEL_PAT):   pat_q   <= wdata;
        default: begin
          go_q  <= wdata[CTL_GO];
          fin_q <= wdata[CTL_FIN];
          w24_q <= wdata[CTL_W24];
          w32_q <= wdata[CTL_W32];
        end
      endcase
    end else if (complete) begin
      go_q  <= 1'b0;
      fin_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mfe_lane_gen.sv
module mfe_lane_gen
  import mfe_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] word_base,
  input  logic [ADDR_W-1:0] first_a,
  input  logic [ADDR_W-1:0] stop_a,
  input  fill_mode_e        mode,
  input  logic [31:0]       pat,
  input  logic [1:0]        ph24,
  output logic [LANES-1:0]  be,
  output logic [31:0]       data
);
  localparam int EXT_W = ADDR_W + 1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] b;
    logic [1:0]        ph;
    logic [2:0]        sum24;
    logic [1:0]        tail;
    logic [EXT_W-1:0]  step_end;
    logic [7:0]        byte_v;

    always_comb begin
      b     = {word_base[ADDR_W-1:2], 2'(l)};
      sum24 = {1'b0, ph24} + 3'(l);
      tail  = 2'd0;
      case (mode)
        FILL16: ph = {1'b0, b[0] ^ first_a[0]};
        FILL32: begin
          ph   = b[1:0] - first_a[1:0];
          tail = 2'd3;
        end
        default: ph = (sum24 >= 3'd3) ? 2'(sum24 - 3'd3) : sum24[1:0];
      endcase
      step_end = {1'b0, b} - EXT_W'(ph) + EXT_W'(tail);
      be[l]    = (b >= first_a) && (step_end < {1'b0, stop_a});
      case (mode)
        FILL16:  byte_v = ph[0] ? pat[15:8] : pat[7:0];
        FILL32:  byte_v = pat[8*ph +: 8];
        default: begin
          if (ph == 2'd0)      byte_v = pat[7:0];
          else if (ph == 2'd1) byte_v = pat[15:8];
          else                 byte_v = pat[23:16];
        end
      endcase
      data[8*l +: 8] = byte_v;
    end
  end
endmodule

// File: rtl/mfe_seq.sv
module mfe_seq
  import mfe_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] first_a,
  input  logic [LANES-1:0]  be,
  input  logic              mem_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] word_base,
  output logic [1:0]        ph24,
  output logic              mem_valid,
  output logic              complete,
  output logic              irq_pulse
);
  logic [1:0] ph_init;

  assign complete  = busy && (be == '0);
  assign mem_valid = busy && (be != '0);

  always_comb begin
    case (first_a[1:0])
      2'd1:    ph_init = 2'd2;
      2'd2:    ph_init = 2'd1;
      default: ph_init = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      word_base <= '0;
      ph24      <= 2'd0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= complete && (first_a != '0);
      if (launch) begin
        busy      <= 1'b1;
        word_base <= {first_a[ADDR_W-1:2], 2'b00};
        ph24      <= ph_init;
      end else if (complete) begin
        busy      <= 1'b0;
      end else if (mem_valid && mem_ready) begin
        word_base <= word_base + ADDR_W'(LANES);
        ph24      <= (ph24 == 2'd2) ? 2'd0 : ph24 + 2'd1;
      end
    end
  end
endmodule

// File: rtl/mem_fill_engine.sv
module mem_fill_engine
  import mfe_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int N_IRQ    = 2,
  parameter int IRQ_LINE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  output logic              busy_o,
  output logic              trig_o,
  output logic              done_o,
  output logic [N_IRQ-1:0]  irq_o
);
  logic [ADDR_W-1:0] first_q, stop_q, word_base;
  logic [31:0]       pat_q;
  fill_mode_e        mode;
  logic              launch, complete, busy, irq_pulse;
  logic [1:0]        ph24;
  logic [LANES-1:0]  be;

  mfe_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .complete(complete), .first_q(first_q), .stop_q(stop_q),
    .pat_q(pat_q), .mode(mode), .go_q(trig_o), .fin_q(done_o), .launch(launch)
  );

  mfe_lane_gen #(.ADDR_W(ADDR_W)) u_lanes (
    .word_base(word_base), .first_a(first_q), .stop_a(stop_q), .mode(mode),
    .pat(pat_q), .ph24(ph24), .be(be), .data(mem_wdata)
  );

  mfe_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .first_a(first_q), .be(be),
    .mem_ready(mem_ready), .busy(busy), .word_base(word_base), .ph24(ph24),
    .mem_valid(mem_valid), .complete(complete), .irq_pulse(irq_pulse)
  );

  assign mem_addr = word_base;
  assign mem_be   = be;
  assign busy_o   = busy;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    if (i == IRQ_LINE) begin : g_own
      assign irq_o[i] = irq_pulse;
    end else begin : g_other
      assign irq_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mfe_chk.sv
module mfe_chk #(
  parameter int ADDR_W   = 16,
  parameter int N_IRQ    = 2,
  parameter int IRQ_LINE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_be,
  input logic              busy_o,
  input logic              trig_o,
  input logic              done_o,
  input logic [N_IRQ-1:0]  irq_o
);
  localparam logic [N_IRQ-1:0] OWN_MASK = N_IRQ'(1) << IRQ_LINE;

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be));

  // R7
  mem_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be != 4'd0) && (mem_addr[1:0] == 2'd0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_valid);

  // R8
  finish_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o && !trig_o);

  // R9
  irq_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[IRQ_LINE] |-> $fell(busy_o) && done_o);

  // R9
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~OWN_MASK) == '0);
endmodule

bind mem_fill_engine mfe_chk #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ), .IRQ_LINE(IRQ_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .busy_o(busy_o),
  .trig_o(trig_o), .done_o(done_o), .irq_o(irq_o)
);

// File: tb/mem_fill_engine_bench.sv
module mem_fill_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int N_IRQ      = 2;
  localparam int IRQ_SEL    = 1;
  localparam int MEMB       = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_sel = 2'd0;
  logic [31:0]       reg_wdata = '0;
  logic              mem_valid;
  logic              mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic [3:0]        mem_be;
  logic              busy_o, trig_o, done_o;
  logic [N_IRQ-1:0]  irq_o;

  int vectors = 0;
  int fails   = 0;
  int irq_cnt = 0;
  int stray   = 0;

  logic [7:0] dut_mem [MEMB];
  logic [7:0] exp_mem [MEMB];
  bit         exp_set [MEMB];

  mem_fill_engine #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ), .IRQ_LINE(IRQ_SEL)) u_mem_fill_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .busy_o(busy_o), .trig_o(trig_o),
    .done_o(done_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, longint act, longint exp, string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every accepted transfer compared against the behavioural byte map (R7, R3, R4, R5)
  always @(posedge clk) begin
    if (rst_n) begin
      if (irq_o[IRQ_SEL]) irq_cnt++;
      if (irq_o[1-IRQ_SEL]) stray++;
      if (mem_valid && mem_ready) begin
        for (int l = 0; l < 4; l++) begin
          if (mem_be[l]) begin
            int a;
            a = int'(mem_addr) + l;
            vectors++;
            if (a >= MEMB || !exp_set[a] || exp_mem[a] != mem_wdata[8*l +: 8]) begin
              fails++;
              $display("FAIL R7 byte write @%0h actual=%0h expected=%0h set=%0d", a,
                       mem_wdata[8*l +: 8], (a < MEMB) ? exp_mem[a] : 8'h0,
                       (a < MEMB) ? exp_set[a] : 1'b0);
            end
            if (a < MEMB) dut_mem[a] = mem_wdata[8*l +: 8];
          end
        end
      end
    end
  end

  always @(negedge clk) mem_ready = ($urandom % 4) != 0;

  task automatic wr(int sel, int data);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = 32'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prep(int s, int e, int v, bit w24, bit w32, bit active);
    for (int i = 0; i < MEMB; i++) begin
      dut_mem[i] = 8'hEE; exp_mem[i] = 8'hEE; exp_set[i] = 1'b0;
    end
    irq_cnt = 0; stray = 0;
    if (active && e > s) begin
      if (w24) begin
        for (int p = s; p < e; p += 3) begin
          exp_mem[p] = v[7:0]; exp_mem[p+1] = v[15:8]; exp_mem[p+2] = v[23:16];
          exp_set[p] = 1; exp_set[p+1] = 1; exp_set[p+2] = 1;
        end
      end else if (w32) begin
        for (int k = 0; k < (e - s) / 4; k++)
          for (int j = 0; j < 4; j++) begin
            exp_mem[s+4*k+j] = v[8*j +: 8]; exp_set[s+4*k+j] = 1;
          end
      end else begin
        for (int p = s; p < e; p += 2) begin
          exp_mem[p] = v[7:0]; exp_mem[p+1] = v[15:8];
          exp_set[p] = 1; exp_set[p+1] = 1;
        end
      end
    end
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy_o && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(req, busy_o, 0, "busy drop");
  endtask

  task automatic compare_mem(string req);
    int bad = 0;
    for (int i = 0; i < MEMB; i++)
      if (dut_mem[i] != exp_mem[i]) begin
        if (bad == 0)
          $display("FAIL %s memory @%0h actual=%0h expected=%0h", req, i, dut_mem[i], exp_mem[i]);
        bad++;
      end
    vectors++;
    if (bad != 0) fails++;
  endtask

  task automatic run_fill(string req, int s, int e, int v, bit w24, bit w32);
    prep(s, e, v, w24, w32, 1'b1);
    wr(0, s); wr(1, e); wr(2, v);
    wr(3, 1 | (int'(w24) << 8) | (int'(w32) << 9));
    chk("R10", busy_o, 1, {req, " busy after start"});
    wait_idle(req);
    // R8: status visible in the first cycle with busy low
    chk("R8", trig_o, 0, {req, " start bit"});
    chk("R8", done_o, 1, {req, " finished bit"});
    @(negedge clk); @(negedge clk);
    compare_mem(req);
    chk("R9", irq_cnt, (s != 0) ? 1 : 0, {req, " irq pulses"});
    chk("R9", stray, 0, {req, " other line"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMB; i++) begin
      dut_mem[i] = 8'hEE; exp_mem[i] = 8'hEE; exp_set[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", busy_o, 0, "reset busy");
    chk("R10", mem_valid, 0, "reset valid");
    chk("R8", trig_o, 0, "reset start bit");
    chk("R8", done_o, 0, "reset finished bit");
    chk("R9", irq_o, 0, "reset irq");

    run_fill("R3 aligned16", 'h10, 'h20, 'h0000_B7A5, 0, 0);
    run_fill("R3 odd16", 'h21, 'h26, 'h0000_3C4D, 0, 0);
    run_fill("R4 fill24", 'h41, 'h4B, 'h0011_2233, 1, 0);
    run_fill("R4 long24", 'h62, 'hA0, 'h00C1_D2E3, 1, 0);
    run_fill("R5 fill32", 'h82, 'h8F, 'h89AB_CDEF, 0, 1);
    run_fill("R5 short32", 'hA0, 'hA3, 'h1234_5678, 0, 1);
    run_fill("R6 both", 'h51, 'h5D, 'h0077_8899, 1, 1);
    run_fill("R8 zero first", 'h0, 'h6, 'h0000_5A5A, 0, 0);

    // R2: stop not above first
    prep('h30, 'h30, 'h1111, 0, 0, 1'b0);
    wr(0, 'h30); wr(1, 'h30); wr(2, 'h1111); wr(3, 1);
    repeat (4) @(negedge clk);
    chk("R2", busy_o, 0, "reject busy");
    chk("R2", trig_o, 1, "reject start bit");
    chk("R2", done_o, 0, "reject finished bit");
    chk("R2", irq_cnt, 0, "reject irq");
    compare_mem("R2 reject");

    // R1: control write with start bit clear
    prep('h40, 'h50, 'h2222, 0, 0, 1'b0);
    wr(0, 'h40); wr(1, 'h50); wr(2, 'h2222); wr(3, 'h2);
    repeat (4) @(negedge clk);
    chk("R1", busy_o, 0, "no start busy");
    chk("R1", trig_o, 0, "no start bit");
    chk("R1", done_o, 1, "finished written");
    compare_mem("R1 no start");

    // R10: writes while busy are discarded
    prep('h100, 'h140, 'h0000_9E6F, 0, 0, 1'b1);
    wr(0, 'h100); wr(1, 'h140); wr(2, 'h9E6F); wr(3, 1);
    chk("R10", busy_o, 1, "busy after start");
    wr(0, 'h300);
    wr(2, 'h0);
    wr(3, 'h201);
    wait_idle("R10");
    @(negedge clk); @(negedge clk);
    compare_mem("R10 first pass");
    chk("R10", irq_cnt, 1, "single completion");
    prep('h100, 'h140, 'h0000_9E6F, 0, 0, 1'b1);
    wr(3, 1);
    wait_idle("R10");
    @(negedge clk); @(negedge clk);
    compare_mem("R10 registers kept");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule